// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit sits in the execute stage of a 64-bit integer pipeline and handles eight bit-field instructions. It decodes a 32-bit instruction word. It cuts a field out of the `rs` operand for the extract forms, or merges low bits of `rs` into the old destination value `rt` for the insert forms. It registers the 64-bit result together with a writeback enable and an illegal flag.

The instruction carries two 5-bit position fields. These cannot name a bit above 31 directly, so the wide forms add a fixed 32 to the field length, to the low position, or to the high position. An insert whose range comes out inverted leaves the destination untouched and does not write back. A mode input gates the six doubleword forms: when it is low, those forms report illegal and do not write back.

Top module: `bitfield_unit`

## Requirements
- R1: While `rst_n` is low, and after it, until the first issued instruction, `result_o` is zero and `wb_en_o` and `illegal_o` are low.
- R2: Decoding uses major opcode `instr_i[31:26]` = 6'b011111, `rs` number [25:21], `rt` number [20:16], high/size field `hf` [15:11], low field `lf` [10:6], and function code [5:0]. Function 0 (word extract) takes `hf`+1 bits of `rs_i[31:0]` starting at bit `lf`, clipped at bit 31, zero-fills above the field, then sign-extends bit 31 into bits 63:32.
- R3: Function 3 takes `hf`+1 bits of `rs_i` from bit `lf`. Function 1 takes `hf`+33 bits from bit `lf`. Function 2 takes `hf`+1 bits from bit `lf`+32. Each form clips at bit 63 and zero-fills above the field.
- R4: Function 4 (word insert) replaces bits `hf`..`lf` of `rt_i` with `rs_i` shifted left by `lf`, then sign-extends bit 31 of that value into bits 63:32.
- R5: Function 7 replaces bits `hf`..`lf` of `rt_i`. Function 5 replaces bits `hf`+32..`lf`. Function 6 replaces bits `hf`+32..`lf`+32 with `rs_i` shifted left by `lf`+32.
- R6: For functions 4, 7 and 6, when `lf` > `hf`, the unit gives `wb_en_o`=0, `illegal_o`=0, and `result_o` equal to `rt_i` unchanged.
- R7: In every insert, each result bit outside the replaced range keeps its `rt_i` value. This holds except for the sign extension of function 4.
- R8: When `wide_en_i` is low, functions 1, 2, 3, 5, 6 and 7 give `illegal_o`=1, `wb_en_o`=0 and `result_o`=`rt_i`. Functions 0 and 4 are not affected by `wide_en_i`. `wb_en_o` and `illegal_o` are never high together.
- R9: When the opcode differs from 6'b011111, or when the function code is above 7, the unit gives `wb_en_o`=0, `illegal_o`=0 and `result_o`=`rt_i`.
- R10: Each output appears one clock after the instruction is presented with `issue_i` high. A cycle with `issue_i` low gives `wb_en_o`=0 and `illegal_o`=0 on the next clock and holds `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction on the inputs is valid this cycle |
| wide_en_i | input | 1 | Enables the doubleword forms |
| instr_i | input | 32 | Instruction word |
| rs_i | input | 64 | Source operand |
| rt_i | input | 64 | Old destination value |
| result_o | output | 64 | Registered result |
| wb_en_o | output | 1 | Result is to be written back |
| illegal_o | output | 1 | Doubleword form issued while disabled |

## Verification
The bound checker checks on every cycle the conditions that depend on decode alone. It checks that writeback and illegal are never both high. It checks that idle cycles are quiet and hold the result, that a disabled doubleword form is flagged, and that unknown codes stay silent. It checks the sign extension of both word forms, and that an inverted word insert returns the old destination. The field contents themselves can only be shown by the bench. Its reference model sweeps every low/size pair for all eight forms, covering the clipping at bit 31 and bit 63, the +32 offsets, and the preservation of bits outside the mask.

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic            wide_en_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic [XLEN-1:0] result_o,
  output logic            wb_en_o,
  output logic            illegal_o
);
  localparam int HALF = XLEN / 2;
  localparam int PW   = $clog2(XLEN) + 2;
  localparam int SW   = $clog2(XLEN);
  localparam logic [5:0] MAJOR = 6'b011111;
  localparam logic [2:0] F_EXT = 3'd0, F_DEXTM = 3'd1, F_DEXTU = 3'd2, F_DEXT = 3'd3,
                         F_INS = 3'd4, F_DINSM = 3'd5, F_DINSU = 3'd6, F_DINS = 3'd7;
  localparam logic [XLEN-1:0] ONES = '1;

  wire [5:0] major = instr_i[31:26];
  wire [4:0] hf    = instr_i[15:11];
  wire [4:0] lf    = instr_i[10:6];
  wire [5:0] fn    = instr_i[5:0];
  wire [2:0] v     = fn[2:0];

  logic            known, inserting, wide_form, inverted, fire;
  logic [PW-1:0]   lo_pos, top, top_c, limit;
  logic [XLEN-1:0] mask, ext_val, ins_val, nxt;

  always_comb begin
    known     = (major == MAJOR) && (fn[5:3] == 3'b000);
    inserting = v[2];
    wide_form = (v != F_EXT) && (v != F_INS);
    lo_pos    = PW'(lf) + ((v == F_DEXTU || v == F_DINSU) ? PW'(HALF) : PW'(0));
    if (inserting)
      top = PW'(hf) + ((v == F_DINSM || v == F_DINSU) ? PW'(HALF) : PW'(0));
    else
      top = lo_pos + PW'(hf) + ((v == F_DEXTM) ? PW'(HALF) : PW'(0));
    limit    = (v == F_EXT || v == F_INS) ? PW'(HALF - 1) : PW'(XLEN - 1);
    top_c    = (top > limit) ? limit : top;
    inverted = inserting && (lo_pos > top);
    mask     = (ONES << lo_pos[SW-1:0]) & (ONES >> SW'(PW'(XLEN - 1) - top_c));
    ext_val  = (rs_i >> lo_pos[SW-1:0]) & (ONES >> SW'(PW'(XLEN - 1) - (top_c - lo_pos)));
    ins_val  = (rt_i & ~mask) | ((rs_i << lo_pos[SW-1:0]) & mask);
    if (v == F_EXT) ext_val = {{HALF{ext_val[HALF-1]}}, ext_val[HALF-1:0]};
    if (v == F_INS) ins_val = {{HALF{ins_val[HALF-1]}}, ins_val[HALF-1:0]};
    fire = known && !inverted && !(wide_form && !wide_en_i);
    nxt  = !fire ? rt_i : (inserting ? ins_val : ext_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      wb_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      wb_en_o   <= issue_i && fire;
      illegal_o <= issue_i && known && wide_form && !wide_en_i;
      if (issue_i) result_o <= nxt;
    end
  end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic            wide_en_i,
  input logic [ILEN-1:0] instr_i,
  input logic [XLEN-1:0] rt_i,
  input logic [XLEN-1:0] result_o,
  input logic            wb_en_o,
  input logic            illegal_o
);
  localparam int HALF = XLEN / 2;
  wire on_major = instr_i[31:26] == 6'b011111;
  wire dword    = on_major && instr_i[5:3] == 3'b000 && instr_i[2:0] != 3'd0 && instr_i[2:0] != 3'd4;

  // R8
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n) !(wb_en_o && illegal_o));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!wb_en_o && !illegal_o));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !issue_i |=> $stable(result_o));
  // R8
  narrow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !wide_en_i && dword) |=> (illegal_o && result_o == $past(rt_i)));
  // R9
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (!on_major || instr_i[5:3] != 3'b000)) |=> (!wb_en_o && !illegal_o && result_o == $past(rt_i)));
  // R2
  wext_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && on_major && instr_i[5:0] == 6'd0) |=> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}));
  // R4
  wins_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && on_major && instr_i[5:0] == 6'd4 && instr_i[10:6] <= instr_i[15:11])
      |=> (wb_en_o && result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}));
  // R6
  inverted_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && on_major && instr_i[5:0] == 6'd4 && instr_i[10:6] > instr_i[15:11])
      |=> (!wb_en_o && !illegal_o && result_o == $past(rt_i)));
endmodule

bind bitfield_unit bitfield_unit_chk #(.XLEN(XLEN), .ILEN(ILEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .wide_en_i(wide_en_i), .instr_i(instr_i),
  .rt_i(rt_i), .result_o(result_o), .wb_en_o(wb_en_o), .illegal_o(illegal_o));

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, issue = 0, wide = 1;
  logic [31:0] instr = '0;
  logic [63:0] rs = '0, rt = '0, res;
  logic wb, ill;
  int n_tests = 0, n_fail = 0;
  logic [63:0] e_res = '0;
  logic e_wb = 0, e_ill = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_unit dut_i (.clk(clk), .rst_n(rst_n), .issue_i(issue), .wide_en_i(wide),
    .instr_i(instr), .rs_i(rs), .rt_i(rt), .result_o(res), .wb_en_o(wb), .illegal_o(ill));

  function automatic void model(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] d,
                                input logic we, output logic [63:0] r, output logic w, output logic il);
    int f, lo, hi, n, lim;
    f = ins[5:0]; r = d; w = 0; il = 0;
    if (ins[31:26] != 6'b011111 || f > 7) return;
    if (f != 0 && f != 4 && !we) begin il = 1; return; end
    if (f < 4) begin
      lo = ins[10:6] + (f == 2 ? 32 : 0);
      n = ins[15:11] + 1 + (f == 1 ? 32 : 0);
      lim = (f == 0) ? 32 : 64;
      r = '0;
      for (int b = 0; b < n; b++) if (lo + b < lim) r[b] = a[lo + b];
      if (f == 0) for (int b = 32; b < 64; b++) r[b] = r[31];
      w = 1;
    end else begin
      lo = ins[10:6] + (f == 6 ? 32 : 0);
      hi = ins[15:11] + ((f == 5 || f == 6) ? 32 : 0);
      if (lo > hi) return;
      for (int b = lo; b <= hi; b++) r[b] = a[b - lo];
      if (f == 4) for (int b = 32; b < 64; b++) r[b] = r[31];
      w = 1;
    end
  endfunction

  task automatic check(input string req);
    n_tests++;
    if (res !== e_res || wb !== e_wb || ill !== e_ill) begin
      n_fail++;
      $display("FAIL %s instr=%h: res=%h wb=%b ill=%b expected res=%h wb=%b ill=%b",
               req, instr, res, wb, ill, e_res, e_wb, e_ill);
    end
  endtask

  task automatic step(input logic is, input logic [31:0] ins, input logic [63:0] a,
                      input logic [63:0] d, input string req);
    logic [63:0] r; logic w, il;
    issue = is; instr = ins; rs = a; rt = d;
    if (is) begin model(ins, a, d, wide, r, w, il); e_res = r; e_wb = w; e_ill = il; end
    else begin e_wb = 0; e_ill = 0; end
    @(posedge clk); #1;
    check(req);
  endtask

  function automatic logic [31:0] enc(int f, int h, int l);
    return {6'b011111, 5'd3, 5'd4, 5'(h), 5'(l), 6'(f)};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    string tags [8] = '{"R2", "R3", "R3", "R3", "R4", "R5", "R5", "R5"};
    #(CLK_PERIOD * 2 + 1);
    check("R1 in reset");
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 after reset");
    // all variants, every low/high pair: R2 R3 R4 R5 R6 R7 R10
    for (int f = 0; f < 8; f++)
      for (int l = 0; l < 32; l++)
        for (int h = 0; h < 32; h++)
          step(1, enc(f, h, l), rnd64(), rnd64(), tags[f]);
    // R7 patterned data: only masked bits change
    for (int f = 4; f < 8; f++) begin
      step(1, enc(f, 9, 3), '0, '1, "R7");
      step(1, enc(f, 20, 20), '1, '0, "R7");
    end
    // R6 inverted ranges
    step(1, enc(4, 2, 5), rnd64(), 64'h0123_4567_89ab_cdef, "R6");
    step(1, enc(7, 0, 31), rnd64(), 64'hfeed_0000_beef_1111, "R6");
    step(1, enc(6, 10, 11), rnd64(), 64'h5555_aaaa_5555_aaaa, "R6");
    // R8 wide forms disabled
    wide = 0;
    for (int f = 0; f < 8; f++) step(1, enc(f, 7, 2), rnd64(), rnd64(), "R8");
    wide = 1;
    // R9 unknown codes
    step(1, enc(8, 5, 1), rnd64(), rnd64(), "R9");
    step(1, enc(6'h3f, 5, 1), rnd64(), rnd64(), "R9");
    step(1, {6'b011110, enc(3, 5, 1)}[31:0] ^ 32'h0400_0000, rnd64(), rnd64(), "R9");
    step(1, {6'b000000, 20'h0, 6'd3}, rnd64(), rnd64(), "R9");
    // R10 idle cycles hold result
    step(1, enc(3, 15, 0), 64'hcafe_f00d_dead_beef, '0, "R10");
    step(0, enc(3, 3, 0), rnd64(), rnd64(), "R10 idle");
    step(0, enc(8, 3, 0), rnd64(), rnd64(), "R10 idle");
    // R1 reset clears outputs
    step(1, enc(3, 31, 0), '1, '0, "R1 pre");
    rst_n = 0; issue = 0; #1;
    e_res = '0; e_wb = 0; e_ill = 0;
    check("R1 async reset");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule